// File: doc/BRIEF.md
# Interleaved Floppy Sector Address Mapper

This block turns a linear logical sector number into the physical track and sector where that sector sits on a 77-track medium with 26 sectors per track. Within a track, consecutive logical sectors take every second physical slot, so the odd slots fill first and the even slots follow. Each new track starts 6 slots further round than the one before it. Logical track 0 is stored on physical track 1. The last logical track wraps round to physical track 0.

The logical number comes from one of two sources. The caller can supply it directly, or as a block number plus a sector index inside that block. For the block form, the density input sets the block size: four sectors at single density and two at double density. Every strobed input gives a registered result exactly one clock later. All arithmetic uses constant divisors and multipliers, so the block accepts a new input on every cycle. An input above the last valid sector raises an error flag and returns zero for the track and sector.

Top module: `sec_interleave_map`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R2: While `rst_n` is low at a rising clock edge, `out_valid`, `out_sector`, `out_track` and `out_err` all become 0.
- R3: Within one track, the remainder r = L mod 26 selects physical slot 2r+1 when r < 13 and slot 2(r-13)+2 otherwise. Logical order therefore visits slots 1,3,...,25 and then 2,4,...,26.
- R4: With q = L div 26, the interleaved slot is moved forward by 6*q positions modulo 26. Example: L=26 gives sector 7 and L=52 gives sector 13.
- R5: `out_track` is q+1, except that q=76 gives track 0.
- R6: A logical number above 2001 sets `out_err` to 1 and sets `out_sector` and `out_track` to 0.
- R7: When `out_err` is 0, `out_sector` lies in 1..26 and `out_track` in 0..76.
- R8: With `in_use_blk`=1, the logical number is `in_blk`*4+`in_idx` when `in_dbl`=0. When `in_dbl`=1 it is `in_blk`*2+`in_idx[0]`, and `in_idx[1]` has no effect. With `in_use_blk`=0, `in_lsn` is used directly.
- R9: Inputs strobed on consecutive cycles each produce their own correct result on consecutive cycles.
- R10: In a cycle after one with `in_valid` low, `out_sector`, `out_track` and `out_err` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_use_blk | input | 1 | 1: form the logical number from block and index |
| in_dbl | input | 1 | Density select for block form (1 = two sectors per block) |
| in_lsn | input | 11 | Direct logical sector number |
| in_blk | input | 10 | Block number |
| in_idx | input | 2 | Sector index within the block |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sector | output | 5 | Physical sector, 1..26 (0 on error) |
| out_track | output | 7 | Physical track, 0..76 (0 on error) |
| out_err | output | 1 | Logical number out of range |

## Verification
The assertions are evaluated on every cycle. They check the one-cycle strobe timing, that results hold while there is no strobe, the zeroing of the error case, the legal ranges of sector and track, and that a remainder in the low half of a track always produces an even interleave index. The actual mapping values can only be shown by the bench's scenarios. These are the slot order within a track, the 6-slot skew, the wrap of the last track to 0, the exact 2001/2002 boundary, and the density-dependent block arithmetic including the ignored index bit. The bench compares all of these against its own model, which is built by repeated subtraction and slot counting.

// File: rtl/sec_map_pkg.sv
package sec_map_pkg;

  // Slot index after a 2:1 interleave, for an even sector count per track.
  function automatic int il_index(input int rem, input int spt);
    return (rem < spt / 2) ? 2 * rem : 2 * rem - (spt - 1);
  endfunction

  // One-based physical sector after the per-track skew.
  function automatic int skewed_sector(input int il, input int quo,
                                       input int spt, input int skew);
    return 1 + (il + skew * quo) % spt;
  endfunction

  // Physical track: one above the quotient, the last one folding to zero.
  function automatic int phys_track(input int quo, input int tracks);
    return (quo + 1 >= tracks) ? 0 : quo + 1;
  endfunction

endpackage

// File: rtl/sec_lsn_select.sv
module sec_lsn_select #(
  parameter int LSN_W  = 11,
  parameter int BLK_W  = 10,
  parameter int IDX_W  = 2,
  parameter int SPB_LO = 4,
  parameter int SPB_HI = 2,
  localparam int LX_W  = LSN_W + 1
) (
  input  logic             use_blk,
  input  logic             dbl,
  input  logic [LSN_W-1:0] lsn_in,
  input  logic [BLK_W-1:0] blk,
  input  logic [IDX_W-1:0] idx,
  output logic [LX_W-1:0]  lsn_out
);
  int blk_i, idx_i, calc;

  always_comb begin
    blk_i = int'(blk);
    idx_i = int'(idx);
    if (dbl) calc = blk_i * SPB_HI + (idx_i % SPB_HI);
    else     calc = blk_i * SPB_LO + (idx_i % SPB_LO);
    if (use_blk) lsn_out = LX_W'(calc);
    else         lsn_out = {1'b0, lsn_in};
  end
endmodule

// File: rtl/sec_track_split.sv
module sec_track_split #(
  parameter int LX_W   = 12,
  parameter int SPT    = 26,
  parameter int TRACKS = 77,
  parameter int Q_W    = 7,
  parameter int R_W    = 5
) (
  input  logic [LX_W-1:0] lsn,
  output logic [Q_W-1:0]  quo,
  output logic [R_W-1:0]  rem,
  output logic            over
);
  localparam int LAST = SPT * TRACKS - 1;
  int l_i;

  always_comb begin
    l_i  = int'(lsn);
    quo  = Q_W'(l_i / SPT);
    rem  = R_W'(l_i % SPT);
    over = (l_i > LAST);
  end
endmodule

// File: rtl/sec_phys_calc.sv
module sec_phys_calc #(
  parameter int SPT    = 26,
  parameter int TRACKS = 77,
  parameter int SKEW   = 6,
  parameter int Q_W    = 7,
  parameter int R_W    = 5
) (
  input  logic [Q_W-1:0] quo,
  input  logic [R_W-1:0] rem,
  output logic [R_W-1:0] il,
  output logic [R_W-1:0] sector,
  output logic [Q_W-1:0] track
);
  import sec_map_pkg::*;
  int il_i;

  always_comb begin
    il_i   = il_index(int'(rem), SPT);
    il     = R_W'(il_i);
    sector = R_W'(skewed_sector(il_i, int'(quo), SPT, SKEW));
    track  = Q_W'(phys_track(int'(quo), TRACKS));
  end
endmodule

// File: rtl/sec_interleave_map.sv
module sec_interleave_map #(
  parameter int SPT    = 26,
  parameter int TRACKS = 77,
  parameter int SKEW   = 6,
  parameter int SPB_LO = 4,
  parameter int SPB_HI = 2,
  parameter int LSN_W  = $clog2(SPT * TRACKS),
  parameter int BLK_W  = $clog2(SPT * TRACKS / SPB_HI),
  parameter int IDX_W  = $clog2(SPB_LO),
  parameter int Q_W    = $clog2(TRACKS),
  parameter int R_W    = $clog2(SPT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_use_blk,
  input  logic             in_dbl,
  input  logic [LSN_W-1:0] in_lsn,
  input  logic [BLK_W-1:0] in_blk,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  output logic [R_W-1:0]   out_sector,
  output logic [Q_W-1:0]   out_track,
  output logic             out_err
);
  localparam int LX_W = LSN_W + 1;

  logic [LX_W-1:0] lsn_w;
  logic [Q_W-1:0]  quo_w;
  logic [R_W-1:0]  rem_w;
  logic            over_w;
  logic [R_W-1:0]  il_w;
  logic [R_W-1:0]  sec_w;
  logic [Q_W-1:0]  trk_w;

  sec_lsn_select #(
    .LSN_W(LSN_W), .BLK_W(BLK_W), .IDX_W(IDX_W),
    .SPB_LO(SPB_LO), .SPB_HI(SPB_HI)
  ) u_sel (
    .use_blk(in_use_blk), .dbl(in_dbl), .lsn_in(in_lsn),
    .blk(in_blk), .idx(in_idx), .lsn_out(lsn_w)
  );

  sec_track_split #(
    .LX_W(LX_W), .SPT(SPT), .TRACKS(TRACKS), .Q_W(Q_W), .R_W(R_W)
  ) u_split (
    .lsn(lsn_w), .quo(quo_w), .rem(rem_w), .over(over_w)
  );

  sec_phys_calc #(
    .SPT(SPT), .TRACKS(TRACKS), .SKEW(SKEW), .Q_W(Q_W), .R_W(R_W)
  ) u_calc (
    .quo(quo_w), .rem(rem_w), .il(il_w), .sector(sec_w), .track(trk_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sector <= '0;
      out_track  <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err    <= over_w;
        out_sector <= over_w ? '0 : sec_w;
        out_track  <= over_w ? '0 : trk_w;
      end
    end
  end
endmodule

// File: rtl/sec_map_checker.sv
module sec_map_checker #(
  parameter int SPT    = 26,
  parameter int TRACKS = 77,
  parameter int Q_W    = 7,
  parameter int R_W    = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           out_valid,
  input logic [R_W-1:0] out_sector,
  input logic [Q_W-1:0] out_track,
  input logic           out_err,
  input logic [R_W-1:0] rem_w,
  input logic [R_W-1:0] il_w
);
  localparam logic [R_W-1:0] HALF  = R_W'(SPT / 2);
  localparam logic [R_W-1:0] TOPS  = R_W'(SPT);
  localparam logic [Q_W-1:0] TOPT  = Q_W'(TRACKS - 1);

  assert_strobe_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |->
      ($stable(out_sector) && $stable(out_track) && $stable(out_err)));

  assert_err_zeroed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_sector == '0 && out_track == '0));

  assert_range_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |->
      (out_sector >= R_W'(1) && out_sector <= TOPS && out_track <= TOPT));

  assert_low_half_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_w < HALF) |-> (il_w[0] == 1'b0));
endmodule

bind sec_interleave_map sec_map_checker #(
  .SPT(SPT), .TRACKS(TRACKS), .Q_W(Q_W), .R_W(R_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_sector(out_sector), .out_track(out_track), .out_err(out_err),
  .rem_w(rem_w), .il_w(il_w)
);

// File: tb/sec_interleave_map_test.sv
module sec_interleave_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_use_blk = 1'b0, in_dbl = 1'b0;
  logic [10:0] in_lsn = '0;
  logic [9:0]  in_blk = '0;
  logic [1:0]  in_idx = '0;
  logic        out_valid, out_err;
  logic [4:0]  out_sector;
  logic [6:0]  out_track;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sec_interleave_map uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_use_blk(in_use_blk),
    .in_dbl(in_dbl), .in_lsn(in_lsn), .in_blk(in_blk), .in_idx(in_idx),
    .out_valid(out_valid), .out_sector(out_sector), .out_track(out_track),
    .out_err(out_err)
  );

  // {logical, sector, track, err}
  localparam int VEC[13][4] = '{
    '{0, 1, 1, 0},   '{1, 3, 1, 0},   '{12, 25, 1, 0}, '{13, 2, 1, 0},
    '{25, 26, 1, 0}, '{26, 7, 2, 0},  '{27, 9, 2, 0},  '{52, 13, 3, 0},
    '{1975, 8, 76, 0}, '{2000, 12, 0, 0}, '{2001, 14, 0, 0},
    '{2002, 0, 0, 1},  '{2047, 0, 0, 1}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Independent model: quotient by subtraction, slot by counting.
  task automatic model(input int l, output int s, output int t, output int e);
    int q = 0, r = l, slot;
    if (l > 2001) begin s = 0; t = 0; e = 1; return; end
    while (r >= 26) begin r -= 26; q++; end
    slot = (r < 13) ? 2 * r : 2 * (r - 13) + 1;   // zero-based slot
    s = ((slot + 6 * q) % 26) + 1;
    t = (q == 76) ? 0 : q + 1;
    e = 0;
  endtask

  task automatic check_out(input string req, input int l);
    int s, t, e;
    model(l, s, t, e);
    chk({req, " valid"}, out_valid, 1);
    chk({req, " sector"}, out_sector, s);
    chk({req, " track"}, out_track, t);
    chk({req, " err"}, out_err, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    in_valid = 1'b1;  // strobe during reset must not leak out (R2)
    repeat (3) @(negedge clk);
    chk("R2 reset valid", out_valid, 0);
    chk("R2 reset sector", out_sector, 0);
    chk("R2 reset track", out_track, 0);
    chk("R2 reset err", out_err, 0);
    rst_n = 1'b1;

    // Table walk, back to back (R3 R4 R5 R6 R9)
    for (int i = 0; i < 13; i++) begin
      in_lsn = 11'(VEC[i][0]);
      @(negedge clk);
      chk("R9 table valid", out_valid, 1);
      chk("R3/R4 table sector", out_sector, VEC[i][1]);
      chk("R5 table track", out_track, VEC[i][2]);
      chk("R6 table err", out_err, VEC[i][3]);
    end

    // Full sweep of direct inputs against the model (R3 R4 R5 R6 R7)
    for (int l = 0; l < 2048; l++) begin
      in_lsn = 11'(l);
      @(negedge clk);
      check_out("R7 sweep", l);
    end

    // Block forms (R8)
    in_use_blk = 1'b1;
    in_dbl = 1'b0; in_blk = 10'd498; in_idx = 2'd0;
    @(negedge clk); check_out("R8 single 498.0", 1992);
    in_blk = 10'd500; in_idx = 2'd1;
    @(negedge clk); check_out("R8 single 500.1", 2001);
    in_blk = 10'd500; in_idx = 2'd2;
    @(negedge clk); check_out("R8 single 500.2", 2002);
    in_blk = 10'd7; in_idx = 2'd3;
    @(negedge clk); check_out("R8 single 7.3", 31);
    in_dbl = 1'b1; in_blk = 10'd1000; in_idx = 2'd1;
    @(negedge clk); check_out("R8 double 1000.1", 2001);
    in_blk = 10'd1001; in_idx = 2'd0;
    @(negedge clk); check_out("R8 double 1001.0", 2002);
    in_blk = 10'd13; in_idx = 2'd3;  // bit 1 of index ignored
    @(negedge clk); check_out("R8 double idx bit1", 27);
    in_blk = 10'd13; in_idx = 2'd2;
    @(negedge clk); check_out("R8 double idx bit1", 26);
    in_use_blk = 1'b0;

    // Idle hold (R1 R10)
    in_lsn = 11'd52;
    @(negedge clk); check_out("R10 pre", 52);
    in_valid = 1'b0; in_lsn = 11'd2047;
    @(negedge clk);
    chk("R1 idle valid", out_valid, 0);
    chk("R10 hold sector", out_sector, 13);
    chk("R10 hold track", out_track, 3);
    chk("R10 hold err", out_err, 0);
    @(negedge clk);
    chk("R10 hold sector 2", out_sector, 13);
    in_valid = 1'b1;
    @(negedge clk); check_out("R1 restart", 2047);

    // Reset in mid run (R2)
    in_lsn = 11'd25; rst_n = 1'b0;
    @(negedge clk);
    chk("R2 mid valid", out_valid, 0);
    chk("R2 mid sector", out_sector, 0);
    chk("R2 mid err", out_err, 0);
    rst_n = 1'b1;
    @(negedge clk); check_out("R2 after", 25);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule